// File: doc/BRIEF.md
# Fractional-N Phase Resync Timer

This block paces the phase realignment of a fractional-N synthesizer. It runs on the phase-detector reference clock. It produces a periodic sync pulse whose spacing is the product of two programmed values: a clock-divider count and the fractional modulus. When software loads a new frequency, it raises a load-enable strobe. The block then skips the next sync pulse and fires a resync strobe on the one after it. The strobe carries a phase word that seeds the sigma-delta modulator, so the output phase settles at a repeatable offset from the reference.

The sync interval is meant to be programmed at least as long as the worst-case lock time of the loop. With that setting, the seed arrives after the settling transient has finished. For example, a 25 MHz reference with a modulus of 125 and a divider of 80 gives a 10,000-cycle interval, which is 400 µs. The seed output is a single-cycle valid strobe with no ready input. The modulator must take the word in the cycle it is presented, and no back-pressure is possible.

Top module: `phase_resync_timer`

## Requirements
- R1: While `rst_n` is low, `sync_pulse` and `seed_valid` are 0 and `seed_word` is 0.
- R2: With `mode` = 2'b10 and both `div_val` and `mod_val` nonzero, `sync_pulse` is high for one cycle every `div_val`×`mod_val` clock cycles. When that product is 1, it is high every cycle. The first pulse comes that many cycles after the counter restarts.
- R3: Only the mode code 2'b10 produces sync pulses. The codes 2'b00, 2'b01 and 2'b11 keep `sync_pulse` low.
- R4: A `div_val` of 0 or a `mod_val` of 0 keeps `sync_pulse` low.
- R5: After a rising edge of `load_en`, the first sync pulse produces no strobe. `seed_valid` is high in the same cycle as the second sync pulse.
- R6: `seed_word` carries the `phase_word` sampled at the `load_en` rising edge. If that value is greater than or equal to `mod_val`, it is replaced by `mod_val`−1. When `seed_valid` is low, `seed_word` is 0.
- R7: A rising edge of `load_en` restarts the period count. No sync pulse follows in the next cycle. A new rising edge before the strobe restarts the two-pulse sequence from the beginning.
- R8: Each rising edge of `load_en` yields at most one one-cycle strobe. Later sync pulses carry no strobe until the next rising edge.
- R9: With `div_val` = 80 and `mod_val` = 125, consecutive sync pulses are 10,000 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W (12) | Clock-divider count, legal range 1 to 4095 |
| mod_val | input | MOD_W (12) | Fractional modulus |
| mode | input | 2 | Resync mode code; 2'b10 enables resync |
| phase_word | input | MOD_W (12) | Requested seed phase, in steps of 360°/modulus |
| load_en | input | 1 | Load strobe; its rising edge arms a resync |
| sync_pulse | output | 1 | One-cycle periodic sync pulse |
| seed_valid | output | 1 | One-cycle resync strobe with no back-pressure |
| seed_word | output | MOD_W (12) | Clamped phase seed, valid with `seed_valid` |

## Verification
The hardest case to reach is a second `load_en` edge that lands between the first and second sync pulse. The stimulus reaches it by waiting past the first pulse of a short period before pulsing `load_en` again. The strobe must then slide to the second pulse counted from the new edge. The full 10,000-cycle example is run for two intervals so that the product-sized period is seen end to end. The clamp is reached by loading a phase word far above a small modulus.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RSV_A  = 2'b01,
    MODE_RESYNC = 2'b10,
    MODE_RSV_B  = 2'b11
  } resync_mode_e;
endpackage

// File: rtl/prt_cycle_counter.sv
module prt_cycle_counter #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic [MOD_W-1:0] mod_val,
  output logic             tc
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [MOD_W-1:0] MOD_ONE = MOD_W'(1);

  logic [MOD_W-1:0] inner_q;
  logic [DIV_W-1:0] outer_q;
  logic             inner_last;
  logic             outer_last;

  // >= keeps the count bounded if a limit shrinks mid-count
  assign inner_last = inner_q >= (mod_val - MOD_ONE);
  assign outer_last = outer_q >= (div_val - DIV_ONE);
  assign tc         = run & inner_last & outer_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (!run) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (inner_last) begin
      inner_q <= '0;
      outer_q <= outer_last ? '0 : outer_q + DIV_ONE;
    end else begin
      inner_q <= inner_q + MOD_ONE;
    end
  end
endmodule

// File: rtl/prt_arm_tracker.sv
module prt_arm_tracker #(
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             tc,
  input  logic [MOD_W-1:0] phase_word,
  input  logic [MOD_W-1:0] mod_val,
  output logic             seed_valid,
  output logic [MOD_W-1:0] seed_word
);
  localparam logic [MOD_W-1:0] MOD_ONE = MOD_W'(1);

  logic             armed_q;
  logic             seen_one_q;
  logic [MOD_W-1:0] phase_q;
  logic             fire;
  logic [MOD_W-1:0] clamped;

  assign fire    = !rise && tc && armed_q && seen_one_q;
  assign clamped = (phase_q >= mod_val) ? (mod_val - MOD_ONE) : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      seen_one_q <= 1'b0;
      phase_q    <= '0;
    end else if (rise) begin
      armed_q    <= 1'b1;
      seen_one_q <= 1'b0;
      phase_q    <= phase_word;
    end else if (tc && armed_q) begin
      if (seen_one_q) armed_q <= 1'b0;
      seen_one_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_valid <= 1'b0;
      seed_word  <= '0;
    end else begin
      seed_valid <= fire;
      seed_word  <= fire ? clamped : '0;
    end
  end
endmodule

// File: rtl/phase_resync_timer.sv
module phase_resync_timer
  import prt_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic [MOD_W-1:0] mod_val,
  input  logic [1:0]       mode,
  input  logic [MOD_W-1:0] phase_word,
  input  logic             load_en,
  output logic             sync_pulse,
  output logic             seed_valid,
  output logic [MOD_W-1:0] seed_word
);
  logic le_q;
  logic rise;
  logic enable;
  logic run;
  logic tc;

  assign rise   = load_en & ~le_q;
  assign enable = (resync_mode_e'(mode) == MODE_RESYNC) && (|div_val) && (|mod_val);
  assign run    = enable & ~rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      le_q       <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      le_q       <= load_en;
      sync_pulse <= tc;
    end
  end

  prt_cycle_counter #(.DIV_W(DIV_W), .MOD_W(MOD_W)) counter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_val (div_val),
    .mod_val (mod_val),
    .tc      (tc)
  );

  prt_arm_tracker #(.MOD_W(MOD_W)) tracker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .tc         (tc),
    .phase_word (phase_word),
    .mod_val    (mod_val),
    .seed_valid (seed_valid),
    .seed_word  (seed_word)
  );
endmodule

// File: rtl/phase_resync_timer_chk.sv
module phase_resync_timer_chk #(
  parameter int DIV_W = 12,
  parameter int MOD_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_val,
  input logic [MOD_W-1:0] mod_val,
  input logic [1:0]       mode,
  input logic             load_en,
  input logic             sync_pulse,
  input logic             seed_valid,
  input logic [MOD_W-1:0] seed_word
);
  // R5
  strobe_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |-> sync_pulse);

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |=> !seed_valid);

  // R6
  seed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_valid |-> (seed_word < $past(mod_val)));

  // R6
  seed_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_valid |-> (seed_word == '0));

  // R3
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'b10) || (div_val == '0) || (mod_val == '0)) |=> !sync_pulse);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |=> !sync_pulse);
endmodule

bind phase_resync_timer phase_resync_timer_chk #(.DIV_W(DIV_W), .MOD_W(MOD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_val    (div_val),
  .mod_val    (mod_val),
  .mode       (mode),
  .load_en    (load_en),
  .sync_pulse (sync_pulse),
  .seed_valid (seed_valid),
  .seed_word  (seed_word)
);

// File: tb/phase_resync_timer_tb_top.sv
`timescale 1ns/100ps
module phase_resync_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] div_val = 12'd3;
  logic [11:0] mod_val = 12'd5;
  logic [1:0]  mode = 2'b10;
  logic [11:0] phase_word = 12'd0;
  logic        load_en = 1'b0;
  logic        sync_pulse;
  logic        seed_valid;
  logic [11:0] seed_word;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  longint cyc = 0;

  always #2.5 clk = ~clk;

  phase_resync_timer dut_i (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .mod_val(mod_val),
    .mode(mode), .phase_word(phase_word), .load_en(load_en),
    .sync_pulse(sync_pulse), .seed_valid(seed_valid), .seed_word(seed_word)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference: elapsed time since restart, pulse tally since edge
  bit     m_sync = 0, m_valid = 0;
  int     m_word = 0;
  bit     le_prev = 0;
  longint elapsed = 0;
  bit     armed = 0;
  int     pulses = 0;
  int     cap = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_sync = 0; m_valid = 0; m_word = 0; le_prev = 0;
      elapsed = 0; armed = 0; pulses = 0; cap = 0;
    end else begin
      bit en, rise, hit, fire;
      longint per;
      en   = (mode == 2'b10) && (div_val != 0) && (mod_val != 0);
      rise = load_en && !le_prev;
      per  = longint'(div_val) * longint'(mod_val);
      hit  = en && !rise && (((elapsed + 1) % per) == 0);
      fire = 0;
      if (rise) begin
        armed = 1; pulses = 0; cap = int'(phase_word);
      end else if (hit && armed) begin
        pulses++;
        if (pulses == 2) begin fire = 1; armed = 0; end
      end
      m_sync  = hit;
      m_valid = fire;
      m_word  = fire ? ((cap >= int'(mod_val)) ? int'(mod_val) - 1 : cap) : 0;
      elapsed = (rise || !en) ? 0 : elapsed + 1;
      le_prev = load_en;
    end
  end

  // event log for directed checks
  int     sync_cnt = 0, seed_cnt = 0, last_word = -1;
  longint last_sync = -1, gap = -1, first_sync = -1, seed_cyc = -1;

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R2", "sync_pulse vs model", sync_pulse, m_sync);
      chk("R5", "seed_valid vs model", seed_valid, m_valid);
      chk("R6", "seed_word vs model", seed_word, m_word);
      if (sync_pulse) begin
        sync_cnt++;
        if (last_sync >= 0) gap = cyc - last_sync;
        if (first_sync < 0) first_sync = cyc;
        last_sync = cyc;
      end
      if (seed_valid) begin
        seed_cnt++; last_word = seed_word; seed_cyc = cyc;
      end
    end
  end

  task automatic clear_log();
    sync_cnt = 0; seed_cnt = 0; last_word = -1;
    last_sync = -1; gap = -1; first_sync = -1; seed_cyc = -1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_le();
    @(negedge clk);
    clear_log();
    load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    wait_cyc(4);
    chk("R1", "sync_pulse in reset", sync_pulse, 0);
    chk("R1", "seed_valid in reset", seed_valid, 0);
    chk("R1", "seed_word in reset", seed_word, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // R2 R5 R6 R8: period 15, strobe on second pulse
    phase_word = 12'd3;
    pulse_le();
    wait_cyc(50);
    chk("R2", "pulse count over 50 cycles", sync_cnt, 3);
    chk("R2", "pulse spacing", gap, 15);
    chk("R5", "strobe on second pulse", seed_cyc - first_sync, 15);
    chk("R6", "seed word", last_word, 3);
    chk("R8", "strobes per edge", seed_cnt, 1);

    // R6: clamp to modulus minus one
    phase_word = 12'd200;
    pulse_le();
    wait_cyc(35);
    chk("R6", "clamped seed word", last_word, 4);

    // R7: a second edge after the first pulse restarts the sequence
    phase_word = 12'd2;
    pulse_le();
    wait_cyc(20);
    chk("R7", "one pulse before re-edge", sync_cnt, 1);
    pulse_le();
    wait_cyc(20);
    chk("R7", "no strobe 20 cycles after re-edge", seed_cnt, 0);
    wait_cyc(15);
    chk("R7", "strobe after restarted pair", seed_cnt, 1);

    // R3: reserved and off codes stay quiet
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      mode = 2'(m);
      pulse_le();
      wait_cyc(40);
      chk("R3", "pulses with disabled code", sync_cnt, 0);
      chk("R3", "strobes with disabled code", seed_cnt, 0);
    end
    mode = 2'b10;

    // R4: zero divider or modulus
    div_val = 12'd0;
    pulse_le();
    wait_cyc(40);
    chk("R4", "pulses with zero divider", sync_cnt, 0);
    div_val = 12'd3; mod_val = 12'd0;
    pulse_le();
    wait_cyc(40);
    chk("R4", "pulses with zero modulus", sync_cnt, 0);

    // R2 R8: product of one pulses every cycle
    div_val = 12'd1; mod_val = 12'd1; phase_word = 12'd0;
    pulse_le();
    wait_cyc(10);
    chk("R2", "unit period spacing", gap, 1);
    chk("R8", "single strobe at unit period", seed_cnt, 1);

    // R9: 80 x 125 example
    div_val = 12'd80; mod_val = 12'd125; phase_word = 12'd60;
    pulse_le();
    wait_cyc(20010);
    chk("R9", "example pulse spacing", gap, 10000);
    chk("R9", "example pulse count", sync_cnt, 2);
    chk("R5", "example strobe count", seed_cnt, 1);
    chk("R6", "example seed word", last_word, 60);

    finish_run();
  end
endmodule